// File: doc/BRIEF.md
# Timer-Aligned Chip-Enable Reset Generator

This block turns a rising chip-enable input into an internal system reset, but it does not reset at once. A rising edge arms a pending request. The reset fires on the next pulse of a periodic basic timer. A built-in prescaler derives that timer pulse from an external slow tick, and a two-bit clock-select register picks the period. Until the pulse arrives, the modelled core keeps running. The core is stood in for by a program counter and a running flag.

The reset lasts one system clock. It loads the program counter with zero and starts the running flag. It leaves the clock-select register alone, so the period chosen before the chip-enable rise stays in force after the reset. If chip enable drops before the timer pulse, the request is withdrawn. A separate power-on reset input clears everything, including the clock-select register.

Top module: `ce_sync_reset`

## Requirements
- R1: `chip_en` is asynchronous and passes through two flops before edge detection. `sys_rst` therefore stays low for at least the first three clock edges after `chip_en` rises.
- R2: A detected rise of `chip_en` sets a pending request. `sys_rst` goes high one clock after the first cycle in which the request is pending, `tmr_pulse` is high and the synchronized enable is still high. No reset is issued on the enable edge itself.
- R3: `tmr_pulse` is a one-cycle pulse, raised one clock after the tick that completes a period. The period is counted in `tick` pulses. The `clk_sel` codes are 0 = 1 tick, 1 = 5 ticks, 2 = 100 ticks and 3 = 250 ticks, which match the 1, 5, 100 and 250 ms settings at a 1 kHz tick. When a tick arrives and the tick count plus one reaches or exceeds the period, the count restarts.
- R4: While a request is pending and no reset has fired, `pc` keeps advancing by one on every clock if `running` is high.
- R5: In the clock after `sys_rst` is high, `pc` is 0 and `running` is 1. Once running, `pc` advances by one per clock, wrapping at its width.
- R6: `sys_rst` is high for exactly one clock per request. The pending request is cleared on the same edge that raises `sys_rst`.
- R7: `sys_rst` does not change `clk_sel`.
- R8: If the enable falls and rises again before the timer pulse, the block still issues only one reset, at the next timer pulse.
- R9: If the synchronized enable is low, any pending request is cancelled, and no reset follows unless a new rise is seen.
- R10: While `por_n` is low, `pc` is 0, `running` is 0, `sys_rst` is 0, `tmr_pulse` is 0 and `clk_sel` is 0 (the 1-tick period).
- R11: When `sel_we` is high at a clock edge, `clk_sel` takes `sel_wdata` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| chip_en | input | 1 | Asynchronous chip-enable level |
| tick | input | 1 | One-cycle timebase tick (nominally 1 kHz) |
| sel_we | input | 1 | Write strobe for the clock-select register |
| sel_wdata | input | 2 | New clock-select code |
| sys_rst | output | 1 | One-cycle internal system reset |
| tmr_pulse | output | 1 | Basic-timer setting pulse |
| clk_sel | output | 2 | Current clock-select code |
| pc | output | PC_W | Program counter of the modelled core |
| running | output | 1 | Core running flag |

## Verification
The assertions assume that `tick` is a one-cycle strobe whose pulses are never closer than two clocks apart. The bench spaces its ticks four clocks apart. The assertions also assume that `chip_en` holds each level for at least one full clock, so the synchronizer never sees a pulse narrower than its sample window. The stimulus changes the enable only in whole-cycle steps, a few cycles or more apart. The clock-select register is written only by single-cycle strobes that occur away from any reset pulse.

// File: rtl/cer_pkg.sv
package cer_pkg;

    typedef enum logic [1:0] {
        SEL_P0 = 2'd0,
        SEL_P1 = 2'd1,
        SEL_P2 = 2'd2,
        SEL_P3 = 2'd3
    } sel_e;

    typedef struct packed {
        logic pend;
        logic fire;
    } pend_st_t;

endpackage

// File: rtl/cer_sync.sv
module cer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.sh[STAGES-1];
    assign rise = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];

endmodule

// File: rtl/cer_prescaler.sv
module cer_prescaler #(
    parameter int DIV0 = 1,
    parameter int DIV1 = 5,
    parameter int DIV2 = 100,
    parameter int DIV3 = 250
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       pulse
);
    localparam int MAXD  = (DIV0 > DIV1 ? DIV0 : DIV1) > (DIV2 > DIV3 ? DIV2 : DIV3)
                         ? (DIV0 > DIV1 ? DIV0 : DIV1) : (DIV2 > DIV3 ? DIV2 : DIV3);
    localparam int CNT_W = $clog2(MAXD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } pre_st_t;

    pre_st_t        st_d, st_q;
    logic [CNT_W:0] lim;
    logic [CNT_W:0] nxt;

    always_comb begin
        case (sel)
            2'd0:    lim = (CNT_W+1)'(DIV0);
            2'd1:    lim = (CNT_W+1)'(DIV1);
            2'd2:    lim = (CNT_W+1)'(DIV2);
            default: lim = (CNT_W+1)'(DIV3);
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        nxt        = {1'b0, st_q.cnt} + 1'b1;
        if (tick) begin
            if (nxt >= lim) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = nxt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    a_r3_pulse_follows_tick: assert property (@(posedge clk) disable iff (!por_n)
        st_q.pulse |-> $past(tick));

endmodule

// File: rtl/cer_pend.sv
module cer_pend
    import cer_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rise,
    input  logic lvl,
    input  logic pulse,
    output logic sys_rst
);
    pend_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d      = st_q;
        hit       = st_q.pend & pulse & lvl;
        st_d.fire = hit;
        if (!lvl || hit) st_d.pend = 1'b0;
        else if (rise)   st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sys_rst = st_q.fire;

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
        st_q.fire |=> !st_q.fire);

    a_r2_fire_on_pulse: assert property (@(posedge clk) disable iff (!por_n)
        st_q.fire |-> ($past(pulse) && $past(st_q.pend)));

    a_r9_cancel_on_low: assert property (@(posedge clk) disable iff (!por_n)
        !lvl |=> !st_q.pend);

    a_r1_arm_after_rise: assert property (@(posedge clk) disable iff (!por_n)
        $rose(st_q.pend) |-> $past(rise));

endmodule

// File: rtl/ce_sync_reset.sv
module ce_sync_reset
    import cer_pkg::*;
#(
    parameter int PC_W        = 12,
    parameter int SYNC_STAGES = 2,
    parameter int DIV0        = 1,
    parameter int DIV1        = 5,
    parameter int DIV2        = 100,
    parameter int DIV3        = 250
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            chip_en,
    input  logic            tick,
    input  logic            sel_we,
    input  logic [1:0]      sel_wdata,
    output logic            sys_rst,
    output logic            tmr_pulse,
    output logic [1:0]      clk_sel,
    output logic [PC_W-1:0] pc,
    output logic            running
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            run;
        sel_e            sel;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     ce_lvl, ce_rise;

    cer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .async_in (chip_en),
        .lvl      (ce_lvl),
        .rise     (ce_rise)
    );

    cer_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_pre (
        .clk   (clk),
        .por_n (por_n),
        .tick  (tick),
        .sel   (st_q.sel),
        .pulse (tmr_pulse)
    );

    cer_pend u_pend (
        .clk     (clk),
        .por_n   (por_n),
        .rise    (ce_rise),
        .lvl     (ce_lvl),
        .pulse   (tmr_pulse),
        .sys_rst (sys_rst)
    );

    always_comb begin
        st_d = st_q;
        if (sys_rst) begin
            st_d.pc  = '0;
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            st_d.pc = st_q.pc + 1'b1;
        end
        if (sel_we) st_d.sel = sel_e'(sel_wdata);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{pc: '0, run: 1'b0, sel: SEL_P0};
        else        st_q <= st_d;
    end

    assign pc      = st_q.pc;
    assign running = st_q.run;
    assign clk_sel = st_q.sel;

    a_r5_pc_cleared: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (pc == '0 && running));

    a_r7_sel_kept: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && !sel_we) |=> $stable(clk_sel));

    a_r11_sel_write: assert property (@(posedge clk) disable iff (!por_n)
        sel_we |=> (clk_sel == $past(sel_wdata)));

endmodule

// File: tb/sim_ce_sync_reset.sv
module sim_ce_sync_reset;
    localparam int PCW  = 12;
    localparam int TDIV = 4;

    logic           clk = 1'b0;
    logic           por_n = 1'b0;
    logic           chip_en = 1'b0;
    logic           tick = 1'b0;
    logic           sel_we = 1'b0;
    logic [1:0]     sel_wdata = 2'd0;
    logic           sys_rst, tmr_pulse, running;
    logic [1:0]     clk_sel;
    logic [PCW-1:0] pc;

    int n_chk = 0;
    int n_bad = 0;
    int rst_cnt = 0;
    int wide_rst = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ce_sync_reset #(.PC_W(PCW)) u0 (
        .clk(clk), .por_n(por_n), .chip_en(chip_en), .tick(tick),
        .sel_we(sel_we), .sel_wdata(sel_wdata), .sys_rst(sys_rst),
        .tmr_pulse(tmr_pulse), .clk_sel(clk_sel), .pc(pc), .running(running)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // tick every TDIV clocks, changed just after the edge
    int tcnt = 0;
    always @(posedge clk) begin
        #1;
        tcnt = (tcnt + 1) % TDIV;
        tick = (tcnt == 0);
    end

    // behavioural reference model
    bit [2:0]       m_hist;
    int             m_ticks;
    bit             m_pulse, m_pend, m_rst, m_run;
    bit [PCW-1:0]   m_pc;
    int             m_sel;

    function automatic int period_of(input int s);
        case (s)
            0: return 1;
            1: return 5;
            2: return 100;
            default: return 250;
        endcase
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_hist <= 3'b000; m_ticks <= 0; m_pulse <= 0; m_pend <= 0;
            m_rst <= 0; m_run <= 0; m_pc <= '0; m_sel <= 0;
        end else begin
            bit lvl, rise, fire;
            lvl  = m_hist[1];
            rise = m_hist[1] && !m_hist[2];
            fire = m_pend && m_pulse && lvl;
            m_hist <= {m_hist[1:0], chip_en};
            if (tick) begin
                if (m_ticks + 1 >= period_of(m_sel)) begin
                    m_ticks <= 0; m_pulse <= 1;
                end else begin
                    m_ticks <= m_ticks + 1; m_pulse <= 0;
                end
            end else m_pulse <= 0;
            m_rst  <= fire;
            m_pend <= lvl && !fire && (m_pend || rise);
            if (m_rst) begin m_pc <= '0; m_run <= 1; end
            else if (m_run) m_pc <= m_pc + 1'b1;
            if (sel_we) m_sel <= int'(sel_wdata);
        end
    end

    bit prev_rst = 0;
    always @(negedge clk) begin
        if (!done) begin
            chk(sys_rst == m_rst, "R2 sys_rst", int'(sys_rst), int'(m_rst));
            chk(tmr_pulse == m_pulse, "R3 tmr_pulse", int'(tmr_pulse), int'(m_pulse));
            chk(pc == m_pc, "R4 pc", int'(pc), int'(m_pc));
            chk(running == m_run, "R5 running", int'(running), int'(m_run));
            chk(int'(clk_sel) == m_sel, "R7 clk_sel", int'(clk_sel), m_sel);
            if (sys_rst) rst_cnt++;
            if (sys_rst && prev_rst) wide_rst++;
            prev_rst = sys_rst;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_pulse();
        step(1);
        while (!tmr_pulse) step(1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int base, p0, t0, gap;
        step(3);
        // R10: reset state
        chk(pc == 0 && running == 0 && sys_rst == 0 && tmr_pulse == 0, "R10 reset outputs",
            int'(pc) + int'(running) + int'(sys_rst) + int'(tmr_pulse), 0);
        chk(clk_sel == 2'd0, "R10 clk_sel", int'(clk_sel), 0);
        por_n = 1'b1;
        step(5);

        // R1 / R2 with 1-tick period
        base = rst_cnt;
        chip_en = 1'b1;
        step(3);
        chk(rst_cnt == base, "R1 no early reset", rst_cnt - base, 0);
        step(20);
        chk(rst_cnt == base + 1, "R2 single reset", rst_cnt - base, 1);
        chk(running == 1'b1, "R5 running after reset", int'(running), 1);

        // R11 / R3: select 5-tick period and measure
        sel_wdata = 2'd1; sel_we = 1'b1;
        step(1);
        sel_we = 1'b0;
        chk(clk_sel == 2'd1, "R11 write", int'(clk_sel), 1);
        wait_pulse();
        wait_pulse();
        t0 = $time;
        wait_pulse();
        gap = (int'($time) - t0) / 4;
        chk(gap == 5 * TDIV, "R3 period 5 ticks", gap, 5 * TDIV);

        // R4 / R7 with 100-tick period
        sel_wdata = 2'd2; sel_we = 1'b1;
        step(1);
        sel_we = 1'b0;
        chip_en = 1'b0;
        step(6);
        base = rst_cnt;
        chip_en = 1'b1;
        step(4);
        p0 = int'(pc);
        step(1);
        if (rst_cnt == base)
            chk(int'(pc) == ((p0 + 1) % (1 << PCW)), "R4 pc advances while pending", int'(pc), (p0 + 1) % (1 << PCW));
        for (int i = 0; i < 600 && rst_cnt == base; i++) step(1);
        chk(rst_cnt == base + 1, "R2 reset at 100-tick pulse", rst_cnt - base, 1);
        step(1);
        chk(clk_sel == 2'd2, "R7 sel kept", int'(clk_sel), 2);
        step(2);
        chk(pc != 0 && running, "R5 pc restarted from zero", int'(pc), 3);

        // R9: cancel with 250-tick period
        sel_wdata = 2'd3; sel_we = 1'b1;
        step(1);
        sel_we = 1'b0;
        chip_en = 1'b0;
        step(6);
        base = rst_cnt;
        chip_en = 1'b1;
        step(10);
        chip_en = 1'b0;
        step(1200);
        chk(rst_cnt == base, "R9 cancelled", rst_cnt - base, 0);

        // R8: fall and re-rise before pulse gives one reset
        base = rst_cnt;
        chip_en = 1'b1;
        step(10);
        chip_en = 1'b0;
        step(3);
        chip_en = 1'b1;
        step(1200);
        chk(rst_cnt == base + 1, "R8 one reset", rst_cnt - base, 1);

        // R10: power-on reset clears select
        por_n = 1'b0;
        step(2);
        chk(clk_sel == 2'd0 && pc == 0 && running == 0, "R10 por clears", int'(clk_sel) + int'(pc), 0);
        por_n = 1'b1;
        step(20);
        chk(wide_rst == 0, "R6 one-cycle reset", wide_rst, 0);
        finish_run();
    end
endmodule